// File: doc/BRIEF.md
# Notch Tuning Code Sweep Calibrator

This controller tunes a notch filter built from switched, binary-weighted grounded capacitors. It drives one tuning code to two identical switch banks. After a start pulse it begins at the all-zero code, which places the notch at its highest frequency. It then raises the code by one LSB per step, which moves the notch steadily down in frequency. While it sweeps, an external test tone passes through the filter. A comparator-based detector reports two flags: an amplitude flag that is high when the tone is suppressed, and a power flag that is high when the filter is alive.

Each step applies the code and waits a programmable settling interval. It then reads the two flags through two-flop synchronizers and makes a decision. A suppressed tone on a live filter ends the sweep and holds the code. A live filter that is not yet tuned moves the sweep on to the next code. A dead filter, or a reading that cannot occur physically, aborts the sweep with an error. If every code is used up without a lock, the controller reports a failure.

Top module: `notch_cal_ctrl`

## Requirements
- R1: After reset, both code outputs are 0 and busy_o, done_o, fail_o and err_o are all low.
- R2: A start_i pulse in idle raises busy_o on the next cycle. The first code applied is 0, and code_a_o always equals code_b_o.
- R3: While busy, the code changes only by an increment of exactly one.
- R4: Every step lasts settle_cycles_i + 2 clock cycles: settle_cycles_i + 1 cycles of settling, then one evaluation cycle. The detector flags pass through a two-flop synchronizer.
- R5: The reading {amp_det_i, pwr_det_i} = 2'b11 ends the sweep. The current code is held, done_o pulses for exactly one cycle, and busy_o falls in that same cycle.
- R6: The reading 2'b01 (power flag high, amplitude flag low) advances to the next code and begins a new step.
- R7: The reading 2'b00 (power flag low) aborts the sweep: err_o goes high, busy_o falls, the code is held and done_o stays low.
- R8: The reading 2'b10 (amplitude flag high, power flag low) is invalid. It aborts the sweep with err_o high, in the same way as R7.
- R9: If code 8'hFF is evaluated without a 2'b11 reading, fail_o goes high, busy_o falls and the code stays at 8'hFF.
- R10: A start_i pulse while busy is ignored: the code does not restart and the step timing does not change.
- R11: A new start clears any fail_o or err_o left by a previous run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a sweep |
| settle_cycles_i | input | SETTLE_W | Settling wait per step, loaded at each code change |
| amp_det_i | input | 1 | Asynchronous flag: test tone suppressed |
| pwr_det_i | input | 1 | Asynchronous flag: filter powered and active |
| code_a_o | output | CODE_W | Tuning code to the first switch bank |
| code_b_o | output | CODE_W | Tuning code to the second switch bank |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle pulse on a successful lock |
| fail_o | output | 1 | Code range exhausted without a lock |
| err_o | output | 1 | Power-off or invalid detector reading |

## Verification
The bench places the lock point at codes spread across the full range, including the first code and the last. At each of these points it checks the held code, the number of busy cycles and the single done pulse. A design that samples too early, or skips a code, locks on the wrong code or shows a different busy length. Separate runs cover an absent lock, which must leave 8'hFF with fail set and not wrap to zero. They also cover a dead filter and the impossible 2'b10 reading, each of which must raise the error at code 0. A start pulse in the middle of a run must not restart the sweep, and a design that accepted it would show a longer busy time. The runs that follow a failure or error show whether the new start clears the flags.

// File: rtl/notch_cal_pkg.sv
package notch_cal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_EVAL   = 2'd2
  } cal_state_e;

  typedef enum logic [1:0] {
    V_LOCK  = 2'd0,
    V_RETRY = 2'd1,
    V_OFF   = 2'd2,
    V_BAD   = 2'd3
  } verdict_e;
endpackage

// File: rtl/ncal_sync.sv
module ncal_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ncal_settle_timer.sv
module ncal_settle_timer #(
  parameter int SETTLE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [SETTLE_W-1:0] load_val_i,
  output logic                expired_o
);
  logic [SETTLE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/ncal_verdict.sv
module ncal_verdict
  import notch_cal_pkg::*;
(
  input  logic     amp_i,
  input  logic     pwr_i,
  output verdict_e verdict_o
);
  always_comb begin
    unique case ({amp_i, pwr_i})
      2'b11:   verdict_o = V_LOCK;
      2'b01:   verdict_o = V_RETRY;
      2'b00:   verdict_o = V_OFF;
      default: verdict_o = V_BAD;
    endcase
  end
endmodule

// File: rtl/notch_cal_ctrl.sv
module notch_cal_ctrl
  import notch_cal_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int SETTLE_W    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [SETTLE_W-1:0] settle_cycles_i,
  input  logic                amp_det_i,
  input  logic                pwr_det_i,
  output logic [CODE_W-1:0]   code_a_o,
  output logic [CODE_W-1:0]   code_b_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                fail_o,
  output logic                err_o
);
  localparam int                NUM_FLAGS = 2;
  localparam logic [CODE_W-1:0] CODE_MAX  = {CODE_W{1'b1}};

  cal_state_e        state_q;
  logic [CODE_W-1:0] code_q;
  logic              done_q, fail_q, err_q;
  logic [NUM_FLAGS-1:0] flag_raw, flag_sync;
  verdict_e          verdict;
  logic              expired, load_timer, at_max;

  assign flag_raw = {amp_det_i, pwr_det_i};

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_sync
    ncal_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (flag_raw[g]),
      .q_o   (flag_sync[g])
    );
  end

  ncal_verdict u_verdict (
    .amp_i    (flag_sync[1]),
    .pwr_i    (flag_sync[0]),
    .verdict_o(verdict)
  );

  assign at_max     = (code_q == CODE_MAX);
  assign load_timer = ((state_q == ST_IDLE) && start_i) ||
                      ((state_q == ST_EVAL) && (verdict == V_RETRY) && !at_max);

  ncal_settle_timer #(.SETTLE_W(SETTLE_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_timer),
    .load_val_i(settle_cycles_i),
    .expired_o (expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      code_q  <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            code_q  <= '0;
            fail_q  <= 1'b0;
            err_q   <= 1'b0;
            state_q <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (expired) state_q <= ST_EVAL;
        end
        ST_EVAL: begin
          unique case (verdict)
            V_LOCK: begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
            V_RETRY: begin
              if (at_max) begin
                fail_q  <= 1'b1;
                state_q <= ST_IDLE;
              end else begin
                code_q  <= code_q + 1'b1;
                state_q <= ST_SETTLE;
              end
            end
            default: begin
              err_q   <= 1'b1;
              state_q <= ST_IDLE;
            end
          endcase
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign code_a_o = code_q;
  assign code_b_o = code_q;
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign fail_o   = fail_q;
  assign err_o    = err_q;
endmodule

// File: rtl/notch_cal_chk.sv
module notch_cal_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [CODE_W-1:0] code_a_o,
  input logic [CODE_W-1:0] code_b_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              fail_o,
  input logic              err_o
);
  AST_BANKS_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_a_o == code_b_o); // R2

  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && (code_a_o != $past(code_a_o))) |->
      (code_a_o == CODE_W'($past(code_a_o) + 1'b1))); // R3

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !err_o && !fail_o)); // R5

  AST_ERR_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> (!busy_o && !done_o)); // R7

  AST_FAIL_AT_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> (code_a_o == {CODE_W{1'b1}})); // R9

  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && $past(start_i)) |-> (code_a_o >= $past(code_a_o))); // R10

  AST_FLAGS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (!fail_o && !err_o)); // R11
endmodule

bind notch_cal_ctrl notch_cal_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .code_a_o(code_a_o),
  .code_b_o(code_b_o),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .fail_o  (fail_o),
  .err_o   (err_o)
);

// File: tb/notch_cal_ctrl_bench.sv
`timescale 1ns/1ps
module notch_cal_ctrl_bench;
  localparam int CODE_W   = 8;
  localparam int SETTLE_W = 16;
  localparam int SETTLE   = 2;
  localparam int STEP_CYC = SETTLE + 2;

  logic                clk = 1'b0;
  logic                rst_ni = 1'b0;
  logic                start_i = 1'b0;
  logic [SETTLE_W-1:0] settle_cycles_i = SETTLE_W'(SETTLE);
  logic                amp_det_i, pwr_det_i;
  logic [CODE_W-1:0]   code_a_o, code_b_o;
  logic                busy_o, done_o, fail_o, err_o;

  int  n_checks = 0, n_fail = 0;
  int  tgt = -1;
  bit  pwr_on = 1'b1;
  bit  force_bad = 1'b0;

  int  run_busy, run_done, step_bad, start_bad, bank_bad;
  logic [CODE_W-1:0] prev_code;
  logic prev_busy;

  always #2 clk = ~clk;

  notch_cal_ctrl #(.CODE_W(CODE_W), .SETTLE_W(SETTLE_W)) u_notch_cal_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .settle_cycles_i(settle_cycles_i),
    .amp_det_i(amp_det_i), .pwr_det_i(pwr_det_i),
    .code_a_o(code_a_o), .code_b_o(code_b_o),
    .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o), .err_o(err_o)
  );

  // detector model
  always_comb begin
    if (force_bad) begin
      amp_det_i = 1'b1;
      pwr_det_i = 1'b0;
    end else begin
      pwr_det_i = pwr_on;
      amp_det_i = pwr_on && (tgt >= 0) && (int'(code_a_o) == tgt);
    end
  end

  always @(negedge clk) begin
    if (busy_o) run_busy++;
    if (done_o) run_done++;
    if (code_a_o != code_b_o) bank_bad++;
    if (busy_o && !prev_busy && code_a_o != '0) start_bad++;
    if (busy_o && prev_busy && code_a_o != prev_code &&
        code_a_o != CODE_W'(prev_code + 1'b1)) step_bad++;
    prev_code = code_a_o;
    prev_busy = busy_o;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_case(input int t, input bit pwr, input bit bad, input bit poke,
                          input int exp_code, input int exp_busy,
                          input bit exp_done, input bit exp_fail, input bit exp_err);
    int wd;
    tgt = t; pwr_on = pwr; force_bad = bad;
    @(negedge clk);
    run_busy = 0; run_done = 0; step_bad = 0; start_bad = 0; bank_bad = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
    check(fail_o == 1'b0 && err_o == 1'b0, "R11 flags cleared", {fail_o, err_o}, 0);
    wd = 0;
    while (busy_o && wd < 4000) begin
      if (poke && wd == 10) start_i = 1'b1;
      else start_i = 1'b0;
      @(negedge clk);
      wd++;
    end
    start_i = 1'b0;
    check(wd < 4000, "R4 run finished", wd, 4000);
    @(negedge clk);
    check(int'(code_a_o) == exp_code, "R5/R7/R9 held code", code_a_o, exp_code);
    check(run_busy == exp_busy, poke ? "R10 busy length" : "R4 busy length",
          run_busy, exp_busy);
    check(run_done == int'(exp_done), "R5 done pulse count", run_done, exp_done);
    check(fail_o == exp_fail, "R9 fail flag", fail_o, exp_fail);
    check(err_o == exp_err, bad ? "R8 err flag" : "R7 err flag", err_o, exp_err);
    check(step_bad == 0, "R3 step by one", step_bad, 0);
    check(start_bad == 0, "R2 first code zero", start_bad, 0);
    check(bank_bad == 0, "R2 banks match", bank_bad, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++; n_checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    prev_code = '0; prev_busy = 1'b0;
    repeat (3) @(negedge clk);
    check(code_a_o == '0 && code_b_o == '0, "R1 code reset", code_a_o, 0);
    check({busy_o, done_o, fail_o, err_o} == 4'b0, "R1 status reset",
          {busy_o, done_o, fail_o, err_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    // R6 sweep: lock points spread across the range
    for (int t = 0; t < 256; t += 3)
      run_case(t, 1'b1, 1'b0, 1'b0, t, (t + 1) * STEP_CYC, 1'b1, 1'b0, 1'b0);
    run_case(255, 1'b1, 1'b0, 1'b0, 255, 256 * STEP_CYC, 1'b1, 1'b0, 1'b0);
    // R9 no lock anywhere
    run_case(-1, 1'b1, 1'b0, 1'b0, 255, 256 * STEP_CYC, 1'b0, 1'b1, 1'b0);
    // R11 after fail, then R7 power off
    run_case(-1, 1'b0, 1'b0, 1'b0, 0, STEP_CYC, 1'b0, 1'b0, 1'b1);
    // R8 invalid reading
    run_case(-1, 1'b1, 1'b1, 1'b0, 0, STEP_CYC, 1'b0, 1'b0, 1'b1);
    // R10 start during busy, R11 after err
    run_case(40, 1'b1, 1'b0, 1'b1, 40, 41 * STEP_CYC, 1'b1, 1'b0, 1'b0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule